// File: doc/BRIEF.md
# SAR Conversion Sequencer with Byte-Swappable Output Bus

This block is the digital half of a 16-bit successive-approximation converter. Two active-low control strobes, a chip select and a read/convert line, are merged into one request line. When that merged line falls, a conversion starts. While the chip select is low and read/convert is high, the output port is enabled for reading. Start requests that arrive while a conversion is running are dropped. They do not restart the conversion and are not queued.

A conversion clears the approximation register and then tries one bit per clock, from the most significant bit down. Each trial code goes to the DAC as offset binary. The bit is kept when the comparator input `cmp_hi` is 1. After the last bit, one load cycle copies the word into the result latch, converted to two's complement. Only then does `ready` return high. The latched result drives a 16-bit output port with a separate enable, so the pads can tri-state it. A byte-select input exchanges the two halves of that port.

Top module: `sar_seq_top`

## Requirements
- R1: The request strobe is the OR of `cs_n` and `rc`. A conversion starts when this strobe falls, whichever input falls last: `rc` falling while `cs_n` is low, or `cs_n` falling while `rc` is low.
- R2: `dbus_oe` is 1 only when `cs_n` is low and `rc` is high. It follows the pins one clock edge after they are sampled and is 0 in every other case.
- R3: At the start of a conversion the approximation register is cleared. The first trial code on `dac_code` is 0x8000.
- R4: Bits are decided from bit 15 down to bit 0, one per clock. Each bit is kept when `cmp_hi` is 1 for its trial. `dac_code` is offset binary: 0x0000 is the most negative input level.
- R5: `ready` is still high at the first negedge after the edge that samples the strobe fall. It is low from the second rising edge after the strobe fall is driven, and stays low for exactly 17 clock cycles (16 bit steps plus one load step).
- R6: When `ready` rises, the port carries the final register word with bit 15 inverted, which is two's complement. The most negative input reads 0x8000 and the most positive reads 0x7FFF.
- R7: A strobe fall while `ready` is low, including one that lands on the load cycle, has no effect. The conversion width and the result are unchanged, and no second conversion follows.
- R8: With `byte_sel` at 0, `dbus_data[15:8]` holds result bits 15:8 and `dbus_data[7:0]` holds bits 7:0. With `byte_sel` at 1, the two bytes are exchanged. `byte_sel` acts without a clock.
- R9: The result latch holds the previous result for the whole conversion. A read enabled while `ready` is low returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rc | input | 1 | Read (high) / convert (low) control |
| byte_sel | input | 1 | 1 exchanges upper and lower output bytes |
| cmp_hi | input | 1 | Comparator decision for the current trial: 1 keeps the bit |
| dac_code | output | 16 | Trial code to the DAC, offset binary |
| ready | output | 1 | Low while a conversion is in progress |
| dbus_data | output | 16 | Output port data from the result latch |
| dbus_oe | output | 1 | Output port enable; 0 means high impedance |

## Verification
Three events can land on the same clock edge: a new start request, the load of a finished result, and a read of the port. The bench provokes the first two together by pulsing the strobe so that its falling edge is decoded exactly in the load cycle. That attempt must be dropped: the measured `ready` width stays at 17, the scoreboard result matches the original target, and `ready` stays high afterwards. The bench also raises `rc` in the middle of a conversion, so that a read overlaps the running conversion. The data seen on the enabled port must then be the previous result until `ready` rises.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_LOAD = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_strobe_decode.sv
// Samples the two control pins, detects the fall of their OR, and forms the read enable.
module sar_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rc,
  output logic start_evt,
  output logic rd_en
);
  logic cs_q, rc_q, strb_d;
  logic strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      rc_q   <= 1'b1;
      strb_d <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      rc_q   <= rc;
      strb_d <= strb;
    end
  end

  assign strb      = cs_q | rc_q;
  assign start_evt = strb_d & ~strb;
  assign rd_en     = ~cs_q & rc_q;

  // R2
  rd_vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !rd_en);
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation state machine, approximation register and result latch.
module sar_engine
  import sar_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_evt,
  input  logic         cmp_hi,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result,
  output logic         ready
);
  localparam int PW = $clog2(W);
  localparam logic [PW-1:0] TOP_IDX = PW'(W - 1);

  sar_state_e     state, state_n;
  logic [PW-1:0]  ptr, ptr_n;
  logic [W-1:0]   sar, sar_n;
  logic [W-1:0]   res_n;
  logic [W-1:0]   trial;
  logic           ld_en;

  assign trial = sar | ({{(W-1){1'b0}}, 1'b1} << ptr);
  assign ld_en = (state == ST_LOAD);
  assign res_n = {~sar[W-1], sar[W-2:0]};

  always_comb begin
    state_n = state;
    ptr_n   = ptr;
    sar_n   = sar;
    unique case (state)
      ST_IDLE: begin
        if (start_evt) begin
          state_n = ST_CONV;
          sar_n   = '0;
          ptr_n   = TOP_IDX;
        end
      end
      ST_CONV: begin
        if (cmp_hi) sar_n = trial;
        if (ptr == '0) state_n = ST_LOAD;
        else           ptr_n   = ptr - 1'b1;
      end
      ST_LOAD: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr   <= '0;
      sar   <= '0;
    end else begin
      state <= state_n;
      ptr   <= ptr_n;
      sar   <= sar_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     result <= '0;
    else if (ld_en) result <= res_n;
  end

  assign dac_code = (state == ST_CONV) ? trial : sar;
  assign ready    = (state == ST_IDLE);

  // R3
  sar_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_evt) |=> (sar == '0 && ptr == TOP_IDX));
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && ptr != '0) |=> (state == ST_CONV && ptr == $past(ptr) - 1'b1));
  // R6
  load_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> (ready && result[W-2:0] == $past(sar[W-2:0])
                            && result[W-1] != $past(sar[W-1])));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LOAD) |=> $stable(result));
endmodule

// File: rtl/sar_byte_lane.sv
// Places the result on the output port, with the two halves exchangeable.
module sar_byte_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         swap,
  output logic [W-1:0] dout
);
  localparam int H = W / 2;

  for (genvar i = 0; i < H; i++) begin : g_lane
    assign dout[i]     = swap ? din[i + H] : din[i];
    assign dout[i + H] = swap ? din[i]     : din[i + H];
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rc,
  input  logic         byte_sel,
  input  logic         cmp_hi,
  output logic [W-1:0] dac_code,
  output logic         ready,
  output logic [W-1:0] dbus_data,
  output logic         dbus_oe
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic         start_evt;
  logic         rd_en;
  logic [W-1:0] result;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sar_strobe_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_n      (cs_n),
    .rc        (rc),
    .start_evt (start_evt),
    .rd_en     (rd_en)
  );

  sar_engine #(.W(W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_evt (start_evt),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .result    (result),
    .ready     (ready)
  );

  sar_byte_lane #(.W(W)) u_lane (
    .din  (result),
    .swap (byte_sel),
    .dout (dbus_data)
  );

  assign dbus_oe = rd_en;

  // R5
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ready) |-> $past(start_evt));
endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rc, byte_sel, cmp_hi;
  logic [15:0] dac_code, dbus_data;
  logic        ready, dbus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] tgt_off = 16'h0000;
  logic [15:0] last_res = 16'h0000;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  // Comparator model: keep the trial bit while the trial level does not exceed the target.
  assign cmp_hi = (dac_code <= tgt_off);

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .byte_sel(byte_sel),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .ready(ready),
    .dbus_data(dbus_data), .dbus_oe(dbus_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: measures ready width, checks first trials, pops the scoreboard at the rising edge of ready.
  int  low_cnt = 0;
  bit  was_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) begin
        low_cnt++;
        if (low_cnt == 1) chk("R3 first trial", dac_code, 16'h8000);
        if (low_cnt == 2) chk("R4 second trial", dac_code, (tgt_off & 16'h8000) | 16'h4000);
        if (dbus_oe && !byte_sel) chk("R9 old data while converting", dbus_data, last_res);
        was_low = 1'b1;
      end else if (was_low) begin
        chk("R5 ready low width", low_cnt, 17);
        if (exp_q.size() == 0) begin
          chk("R6 scoreboard underflow", 1, 0);
        end else begin
          last_res = exp_q.pop_front();
          chk("R6 result at ready rise", dbus_data, last_res);
        end
        low_cnt = 0;
        was_low = 1'b0;
      end
    end
  end

  // Driver: mode 0 starts with rc falling under cs_n low, mode 1 with cs_n falling under rc low.
  // k >= 3 pulses the strobe again k negedges after the start, which must be ignored (R7).
  task automatic convert(logic [15:0] tgt, int mode, int k);
    @(negedge clk);
    if (mode == 0) begin cs_n = 1'b0; rc = 1'b1; end
    else           begin cs_n = 1'b1; rc = 1'b0; end
    repeat (2) @(negedge clk);
    tgt_off = tgt ^ 16'h8000;
    exp_q.push_back(tgt);
    if (mode == 0) rc = 1'b0;
    else           cs_n = 1'b0;
    @(negedge clk);
    chk("R5 ready still high one edge after sample", ready, 1'b1);
    @(negedge clk);
    chk("R1 conversion started", ready, 1'b0);
    if (mode == 1) chk("R2 port disabled while rc low", dbus_oe, 1'b0);
    if (k >= 3) begin
      repeat (k - 2) @(negedge clk);
      if (mode == 0) rc = 1'b1; else cs_n = 1'b1;
      @(negedge clk);
      if (mode == 0) rc = 1'b0; else cs_n = 1'b0;
      repeat (2) @(negedge clk);
      if (mode == 0) rc = 1'b1;
    end else if (mode == 0) begin
      @(negedge clk);
      rc = 1'b1;
    end
    while (!ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 no queued conversion", ready, 1'b1);
    cs_n = 1'b1;
    rc   = 1'b1;
  endtask

  task automatic read_check(logic [15:0] exp);
    @(negedge clk);
    cs_n = 1'b1; rc = 1'b1; byte_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 disabled with cs_n high", dbus_oe, 1'b0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R2 enabled by cs_n fall with rc high", dbus_oe, 1'b1);
    chk("R6 read word", dbus_data, exp);
    byte_sel = 1'b1;
    #1;
    chk("R8 bytes exchanged", dbus_data, {exp[7:0], exp[15:8]});
    byte_sel = 1'b0;
    #1;
    chk("R8 bytes restored", dbus_data, exp);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 disabled after cs_n rise", dbus_oe, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rc = 1'b1; byte_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 ready after reset", ready, 1'b1);
    chk("R2 port off after reset", dbus_oe, 1'b0);
    chk("R9 latch cleared by reset", dbus_data, 16'h0000);
    chk("R3 idle dac code", dac_code, 16'h0000);

    convert(16'h1234, 0, 0);  read_check(16'h1234);
    convert(16'h8000, 1, 0);  read_check(16'h8000);  // R6 most negative
    convert(16'h7FFF, 0, 0);  read_check(16'h7FFF);  // R6 most positive
    convert(16'hFFFF, 1, 0);  read_check(16'hFFFF);
    convert(16'h0000, 0, 0);  read_check(16'h0000);
    convert(16'hA5C3, 0, 5);  read_check(16'hA5C3);  // R7 mid-conversion attempt
    convert(16'h3C0F, 0, 16); read_check(16'h3C0F);  // R7 attempt decoded in the load cycle
    convert(16'h5A96, 1, 16); read_check(16'h5A96);  // R1 second strobe order, R7 load cycle

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule